// File: doc/BRIEF.md
# Power-of-Two SPI Bit-Clock Generator

This block sits in the control path of an SPI-style master and drives the serial clock from a fast reference clock. Each attached device has its own parameter word and its own clock polarity and phase bits. The parameter word carries a rate code and three timing counts: select setup, select hold and the gap between transfers. When a run is requested, the block latches the values for the chosen device and asserts select. It waits out the setup time and then toggles SCK. With every edge it emits a one-cycle launch or capture strobe. A separate shift path uses these strobes to move data.

The rate comes from an 8-bit accumulator that adds the effective rate code on every reference cycle. Each carry out of the accumulator ends one SCK half-period. The full bit rate is therefore the reference times code over 512, which runs from reference/512 up to reference/4. A run continues for as long as the request stays high. The block always finishes the bit that is in progress, holds select for the hold count, and then stays idle for the gap count before it accepts a new request.

Top module: `spi_bitclk_gen`

## Requirements
- R1: During reset, and after it while idle, selActive, launchStb and captureStb are 0 and busPhase is 0 (idle). While idle, sck follows the polarity bit of the device that chipSel currently addresses, with a delay of one cycle.
- R2: One SCK half-period lasts 256/p reference cycles, where p is the effective rate code. Consecutive SCK edges are exactly that far apart.
- R3: The effective rate code is the raw code rounded down to a power of two. A raw code of 0 counts as 1. For example, 0x90 and 0xFF give 128, and 3 gives 2.
- R4: The parameter word for device n occupies devTable bits [32n+31:32n]. Within that word, the rate code is in bits 31:24, setup in 23:16, hold in 15:8 and gap in 7:0. activeDev reports the device that was latched at the start of the run.
- R5: The polarity bit for device n is modeWord bit 19−n, and the phase bit is bit 14−n. After edge k of a run, sck equals polarity XOR (k odd).
- R6: The first SCK edge comes (setup+1) half-periods after selActive rises. Edge k comes (setup+k) half-periods after it.
- R7: Every SCK edge carries exactly one strobe, and no strobe appears without an edge. On leading (odd) edges, phase 0 gives capture and phase 1 gives launch. Trailing edges carry the other strobe.
- R8: A run ends on the first trailing edge at which runReq is low. The number of edges is twice the number of bits, and sck then rests at the polarity level.
- R9: selActive falls (hold+1) half-periods after the last edge.
- R10: busPhase encodes 0 as idle, 1 as setup, 2 as active, 3 as hold and 4 as gap. The gap phase lasts (gap+1) half-periods. A request made during the gap is ignored, and such a request starts the next run one cycle after the block returns to idle.
- R11: While enable is low, a request in the idle phase does not start a run.
- R12: Rate, timing counts, polarity and phase are latched when the run starts. Changes to devTable, modeWord or chipSel during a run have no effect on that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Allows a run to start |
| runReq | input | 1 | Run request, level sensitive |
| chipSel | input | 3 | Device to address |
| devTable | input | NUM_CS*32 | Per-device parameter words |
| modeWord | input | 32 | Per-device polarity and phase bits |
| sck | output | 1 | Serial clock |
| launchStb | output | 1 | Strobe: drive the next data bit |
| captureStb | output | 1 | Strobe: sample the incoming bit |
| selActive | output | 1 | Select asserted (setup, active, hold) |
| busPhase | output | 3 | Current timing phase |
| activeDev | output | 3 | Device latched for the current run |

## Verification
The bench checks the edge times against the exact cycle numbers predicted by the setup, hold and gap formulas. An error of one half-period, or a setup that omits its minimum half-period, therefore shows up as a wrong cycle count. Rate codes of 0, 3, 0x90 and 0xFF test the rounding rule: a design that used the raw code, or stalled on zero, would produce edges at the wrong spacing or none at all. Runs are chained, with the next request raised during the gap. This exposes a design that restarts early, and the parameter table is rewritten during every run to catch values that are read live instead of latched. Every strobe is compared against the phase rule per edge, so a swapped or missing launch or capture is caught at the edge where it happens.

// File: rtl/spi_bclk_pkg.sv
package spi_bclk_pkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_SETUP  = 3'd1,
    PH_ACTIVE = 3'd2,
    PH_HOLD   = 3'd3,
    PH_GAP    = 3'd4
  } busPhase_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic accClear;
    logic cntClear;
    logic cntInc;
  } ctlStb_t;

endpackage

// File: rtl/spi_bclk_datapath.sv
module spi_bclk_datapath
  import spi_bclk_pkg::*;
#(
  parameter int NUM_CS  = 5,
  parameter int FIELD_W = 8,
  parameter int CS_W    = 3,
  parameter int POL_TOP = 19,
  parameter int PHA_TOP = 14
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [CS_W-1:0]             chipSel,
  input  logic [NUM_CS*4*FIELD_W-1:0] devTable,
  input  logic [31:0]                 modeWord,
  input  ctlStb_t                     ctl,
  input  busPhase_t                   phase,
  output logic                        tick,
  output logic                        cntDone,
  output logic                        idlePol,
  output logic                        polQ,
  output logic                        phaQ,
  output logic [CS_W-1:0]             devSelQ
);

  localparam int WORD_W    = 4 * FIELD_W;
  localparam int CODE_LSB  = 3 * FIELD_W;
  localparam int SETUP_LSB = 2 * FIELD_W;
  localparam int HOLD_LSB  = FIELD_W;
  localparam int GAP_LSB   = 0;

  logic [WORD_W-1:0] words [NUM_CS];

  genvar g;
  generate
    for (g = 0; g < NUM_CS; g++) begin : gWord
      assign words[g] = devTable[g*WORD_W +: WORD_W];
    end
  endgenerate

  logic [WORD_W-1:0] liveWord;
  logic              livePha;

  always_comb begin
    liveWord = '0;
    idlePol  = 1'b0;
    livePha  = 1'b0;
    for (int i = 0; i < NUM_CS; i++) begin
      if (chipSel == CS_W'(i)) begin
        liveWord = words[i];
        idlePol  = modeWord[POL_TOP-i];
        livePha  = modeWord[PHA_TOP-i];
      end
    end
  end

  function automatic logic [FIELD_W-1:0] roundPow2(input logic [FIELD_W-1:0] raw);
    logic [FIELD_W-1:0] r;
    r    = '0;
    r[0] = 1'b1;
    for (int i = 0; i < FIELD_W; i++) begin
      if (raw[i]) begin
        r    = '0;
        r[i] = 1'b1;
      end
    end
    return r;
  endfunction

  logic [FIELD_W-1:0] codeQ, setupQ, holdQ, gapQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      codeQ    <= FIELD_W'(1);
      setupQ   <= '0;
      holdQ    <= '0;
      gapQ     <= '0;
      polQ     <= 1'b0;
      phaQ     <= 1'b0;
      devSelQ  <= '0;
    end else if (ctl.load) begin
      codeQ    <= roundPow2(liveWord[CODE_LSB +: FIELD_W]);
      setupQ   <= liveWord[SETUP_LSB +: FIELD_W];
      holdQ    <= liveWord[HOLD_LSB +: FIELD_W];
      gapQ     <= liveWord[GAP_LSB +: FIELD_W];
      polQ     <= idlePol;
      phaQ     <= livePha;
      devSelQ  <= chipSel;
    end
  end

  // rate accumulator: carry ends one half-period
  logic [FIELD_W-1:0] acc;
  logic [FIELD_W:0]   sum;

  assign sum  = {1'b0, acc} + {1'b0, codeQ};
  assign tick = sum[FIELD_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            acc <= '0;
    else if (ctl.accClear) acc <= '0;
    else                   acc <= sum[FIELD_W-1:0];
  end

  // half-period counter for setup, hold and gap
  logic [FIELD_W-1:0] cnt;
  logic [FIELD_W-1:0] target;

  always_comb begin
    case (phase)
      PH_SETUP: target = setupQ;
      PH_HOLD:  target = holdQ;
      PH_GAP:   target = gapQ;
      default:  target = '0;
    endcase
  end

  assign cntDone = (cnt == target);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (ctl.cntClear) cnt <= '0;
    else if (ctl.cntInc)   cnt <= cnt + 1'b1;
  end

  AST_CODE_POW2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(codeQ) == 1); // R3

  AST_SETUP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_SETUP) |-> (cnt <= setupQ)); // R6

  AST_HOLD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_HOLD) |-> (cnt <= holdQ)); // R9

endmodule

// File: rtl/spi_bclk_control.sv
module spi_bclk_control
  import spi_bclk_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      enable,
  input  logic      runReq,
  input  logic      tick,
  input  logic      cntDone,
  input  logic      idlePol,
  input  logic      polQ,
  input  logic      phaQ,
  output ctlStb_t   ctl,
  output busPhase_t phase,
  output logic      sck,
  output logic      launchStb,
  output logic      captureStb
);

  busPhase_t state, nxt;
  logic      leadNext;
  logic      doEdge;

  assign phase = state;

  always_comb begin
    ctl    = '0;
    nxt    = state;
    doEdge = 1'b0;
    case (state)
      PH_IDLE: begin
        ctl.accClear = 1'b1;
        ctl.cntClear = 1'b1;
        if (enable && runReq) begin
          ctl.load = 1'b1;
          nxt      = PH_SETUP;
        end
      end
      PH_SETUP: if (tick) begin
        if (cntDone) begin
          doEdge = 1'b1;
          nxt    = PH_ACTIVE;
        end else begin
          ctl.cntInc = 1'b1;
        end
      end
      PH_ACTIVE: if (tick) begin
        doEdge = 1'b1;
        if (!leadNext && !runReq) begin
          nxt          = PH_HOLD;
          ctl.cntClear = 1'b1;
        end
      end
      PH_HOLD: if (tick) begin
        if (cntDone) begin
          nxt          = PH_GAP;
          ctl.cntClear = 1'b1;
        end else begin
          ctl.cntInc = 1'b1;
        end
      end
      PH_GAP: if (tick) begin
        if (cntDone) nxt = PH_IDLE;
        else         ctl.cntInc = 1'b1;
      end
      default: nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= PH_IDLE;
      leadNext   <= 1'b1;
      sck        <= 1'b0;
      launchStb  <= 1'b0;
      captureStb <= 1'b0;
    end else begin
      state      <= nxt;
      launchStb  <= doEdge & (leadNext ? phaQ : ~phaQ);
      captureStb <= doEdge & (leadNext ? ~phaQ : phaQ);
      if (state == PH_IDLE) begin
        sck      <= idlePol;
        leadNext <= 1'b1;
      end else if (doEdge) begin
        sck      <= ~sck;
        leadNext <= ~leadNext;
      end
    end
  end

  AST_STB_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(launchStb && captureStb)); // R7

  AST_SCK_HAS_STB: assert property (@(posedge clk) disable iff (!rst_n)
    ((sck != $past(sck)) && ($past(state) != PH_IDLE)) |-> (launchStb || captureStb)); // R7

  AST_STB_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (launchStb || captureStb) |-> (state == PH_ACTIVE || state == PH_HOLD)); // R8

  AST_HOLD_SCK_REST: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PH_HOLD) |-> (sck == polQ)); // R8

  AST_NO_START_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PH_IDLE && !enable) |=> (state == PH_IDLE)); // R11

endmodule

// File: rtl/spi_bitclk_gen.sv
module spi_bitclk_gen
  import spi_bclk_pkg::*;
#(
  parameter int NUM_CS  = 5,
  parameter int FIELD_W = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        enable,
  input  logic                        runReq,
  input  logic [2:0]                  chipSel,
  input  logic [NUM_CS*4*FIELD_W-1:0] devTable,
  input  logic [31:0]                 modeWord,
  output logic                        sck,
  output logic                        launchStb,
  output logic                        captureStb,
  output logic                        selActive,
  output logic [2:0]                  busPhase,
  output logic [2:0]                  activeDev
);

  ctlStb_t   ctl;
  busPhase_t phase;
  logic      tick, cntDone, idlePol, polQ, phaQ;

  spi_bclk_datapath #(
    .NUM_CS (NUM_CS),
    .FIELD_W(FIELD_W),
    .CS_W   (3)
  ) uDp (
    .clk     (clk),
    .rst_n   (rst_n),
    .chipSel (chipSel),
    .devTable(devTable),
    .modeWord(modeWord),
    .ctl     (ctl),
    .phase   (phase),
    .tick    (tick),
    .cntDone (cntDone),
    .idlePol (idlePol),
    .polQ    (polQ),
    .phaQ    (phaQ),
    .devSelQ (activeDev)
  );

  spi_bclk_control uCtl (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .runReq    (runReq),
    .tick      (tick),
    .cntDone   (cntDone),
    .idlePol   (idlePol),
    .polQ      (polQ),
    .phaQ      (phaQ),
    .ctl       (ctl),
    .phase     (phase),
    .sck       (sck),
    .launchStb (launchStb),
    .captureStb(captureStb)
  );

  assign busPhase  = phase;
  assign selActive = (phase == PH_SETUP) || (phase == PH_ACTIVE) || (phase == PH_HOLD);

endmodule

// File: tb/spi_bitclk_gen_test.sv
`timescale 1ns/1ps
module spi_bitclk_gen_test;

  localparam int NCS = 5;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             enable = 1'b0;
  logic             runReq = 1'b0;
  logic [2:0]       chipSel = '0;
  logic [NCS*32-1:0] devTable = '0;
  logic [31:0]      modeWord = '0;
  logic             sck, launchStb, captureStb, selActive;
  logic [2:0]       busPhase, activeDev;

  always #2.5 clk = ~clk;

  spi_bitclk_gen #(.NUM_CS(NCS)) uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .runReq(runReq),
    .chipSel(chipSel), .devTable(devTable), .modeWord(modeWord),
    .sck(sck), .launchStb(launchStb), .captureStb(captureStb),
    .selActive(selActive), .busPhase(busPhase), .activeDev(activeDev)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  int prevIdleExp = 0;

  task automatic check(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int halfOf(int code);
    int p;
    p = 1;
    if (code != 0) while (p * 2 <= code) p = p * 2;
    return 256 / p;
  endfunction

  task automatic setDev(int cs, int code, int su, int hd, int gp, bit pol, bit pha);
    devTable[cs*32 +: 32] = {code[7:0], su[7:0], hd[7:0], gp[7:0]};
    modeWord[19-cs] = pol;
    modeWord[14-cs] = pha;
  endtask

  task automatic runOne(int cs, int code, int su, int hd, int gp,
                        bit pol, bit pha, int bits, bit chained);
    int h, tSel, n;
    bit prevSck;
    h = halfOf(code);
    setDev(cs, code, su, hd, gp, pol, pha);
    chipSel = 3'(cs);
    runReq  = 1'b1;
    @(negedge clk);
    while (!selActive) @(negedge clk);
    tSel = cyc;
    if (chained) check("R10", "restart cycle", tSel, prevIdleExp + 1);
    check("R4", "activeDev", activeDev, cs);
    check("R1", "sck at select", sck, pol);
    // R12: scramble all parameters mid-run
    devTable = {$urandom, $urandom, $urandom, $urandom, $urandom};
    modeWord = $urandom;
    chipSel  = 3'($urandom % NCS);
    prevSck = sck;
    n = 0;
    while (selActive) begin
      @(negedge clk);
      if (sck != prevSck) begin
        n++;
        if (n == 1) check("R6", "first edge time", cyc, tSel + (su + 1) * h);
        else        check("R2", "edge time", cyc, tSel + (su + n) * h);
        check("R5", "sck level", sck, pol ^ n[0]);
        check("R7", "capture strobe", captureStb, n[0] ? !pha : pha);
        check("R7", "launch strobe", launchStb, n[0] ? pha : !pha);
        if (n == 2 * bits - 1) runReq = 1'b0;
        prevSck = sck;
      end else if (launchStb || captureStb) begin
        check("R7", "stray strobe", 1, 0);
      end
    end
    check("R9", "select drop time", cyc, tSel + (su + 2 * bits + hd + 1) * h);
    check("R8", "edge count", n, 2 * bits);
    check("R8", "sck at rest", sck, pol);
    check("R10", "gap phase code", busPhase, 4);
    prevIdleExp = cyc + (gp + 1) * h;
  endtask

  task automatic finishIdle();
    @(negedge clk);
    while (busPhase != 3'd0) @(negedge clk);
    check("R10", "idle return time", cyc, prevIdleExp);
  endtask

  initial begin
    bit seenSel;
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    check("R1", "reset selActive", selActive, 0);
    check("R1", "reset phase", busPhase, 0);
    check("R1", "reset strobes", launchStb | captureStb, 0);
    rst_n = 1'b1;
    chipSel = 3'd2;
    modeWord[17] = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", "idle sck follows pol cs2", sck, 1);
    chipSel = 3'd3;
    repeat (2) @(negedge clk);
    check("R1", "idle sck follows pol cs3", sck, 0);

    // R11: enable low blocks start
    runReq = 1'b1;
    seenSel = 1'b0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (selActive || busPhase != 3'd0) seenSel = 1'b1;
    end
    check("R11", "no start while disabled", seenSel, 0);
    runReq = 1'b0;
    enable = 1'b1;
    @(negedge clk);

    // directed corners
    runOne(0, 128, 0, 0, 0, 0, 0, 3, 0);
    runOne(1, 8'h90, 2, 1, 3, 1, 1, 2, 1);
    runOne(4, 3, 1, 0, 0, 0, 1, 1, 1);
    runOne(2, 0, 0, 0, 0, 1, 0, 1, 1);
    runOne(3, 8'hFF, 4, 2, 1, 1, 1, 2, 1);
    finishIdle();

    // constrained random
    for (int k = 0; k < 24; k++) begin
      int code, su, hd, gp, bits, cs;
      bit pol, pha, chain;
      code  = 16 + ($urandom % 240);
      su    = $urandom % 6;
      hd    = $urandom % 6;
      gp    = $urandom % 6;
      bits  = 1 + ($urandom % 4);
      cs    = $urandom % NCS;
      pol   = 1'($urandom);
      pha   = 1'($urandom);
      chain = 1'($urandom);
      if (!chain) finishIdle();
      runOne(cs, code, su, hd, gp, pol, pha, bits, chain);
    end
    finishIdle();

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule